// File: doc/BRIEF.md
# Endian-Switchable Aligned Load/Store Lane Unit

This unit sits between the load/store stage of a pipeline and a byte-addressed data memory with a 32-bit word port. It accepts one request per cycle: an address, an access size (byte, halfword or word), a load/store selector, store data, a signedness selector for narrow loads, and a byte-order mode. The byte-order mode may change from one request to the next.

For a store, the unit forms the word address and the byte-lane write enables. It also builds the lane image of the operand, laid out in big- or little-endian order. For a load, it forms the word address and a read strobe. It keeps the size, byte offset, signedness and byte order in a one-entry context register. One cycle later it uses that context to pull the operand out of the returned memory word and extend it to 32 bits.

A request whose address is not a multiple of its size is flagged in the cycle it is presented. Such a request produces no write enable and no read strobe.

Top module: `mem_access_unit`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two least significant bits forced to zero.
- R2: Size code 0 is a byte, code 1 is a halfword and code 2 is a word. A byte access is always aligned. A halfword access is aligned only when address bit 0 is zero. A word access is aligned only when address bits 1:0 are zero. Size code 3 is never aligned.
- R3: A valid request that is not aligned raises `misalign` in the same cycle. In that cycle `mem_wen` is 4'b0000 and `mem_ren` is low, so the memory is left unchanged and no load result appears.
- R4: An aligned store asserts write enables only for the lanes it covers. A byte store enables lane `addr[1:0]`. A halfword store enables lanes `addr[1:0]` and `addr[1:0]+1`. A word store enables all four lanes. Lane i is bit i of `mem_wen`.
- R5: Lane i of `mem_wdata` and `mem_rdata` (bits 8i+7:8i) carries the byte at address `mem_addr + i`.
- R6: With `big_endian` low, the least significant byte of an operand sits at its lowest byte address.
- R7: With `big_endian` high, the most significant byte of an operand sits at its lowest byte address.
- R8: A byte store copies the byte into all four lanes of `mem_wdata`. A halfword store places its two-byte lane image (ordered per R6/R7) in both halves of `mem_wdata`.
- R9: An aligned load asserts `mem_ren` in its request cycle. On the following cycle `load_valid` is high and `load_data` holds the operand taken from `mem_rdata`. `load_valid` is low in every other cycle.
- R10: A byte or halfword load with `req_signed` high is sign-extended to 32 bits. With `req_signed` low it is zero-extended. A word load returns the 32-bit value unchanged.
- R11: The size, offset, signedness and byte order applied to a load result are those present in the request cycle. Changes to `big_endian` or the request inputs in the result cycle have no effect on that result.
- R12: While `rst_n` is low, `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend narrow loads when high |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store operand, right-justified |
| big_endian | input | 1 | Byte order mode: 1 big, 0 little |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wen | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_ren | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Memory word returned one cycle after `mem_ren` |
| misalign | output | 1 | Request rejected for misalignment |
| load_valid | output | 1 | `load_data` holds a result |
| load_data | output | 32 | Aligned and extended load operand |

## Verification
A corrupted load context register shows up at the ports on the very next cycle. The fault appears as a result taken from the wrong lanes, an extension of the wrong sign, reversed byte order, or a `load_valid` pulse that is missing or spurious. A wrong lane mask or lane image on a store shows nothing in its own cycle. It only becomes visible when a later load reads the damaged bytes. For that reason the bench reads every store back, across both byte orders and all sizes. The bench's reference byte array is updated by address semantics rather than by lanes, so a steering error appears as a mismatch on the read-back.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    size_e            size;
    logic [OFF_W-1:0] offset;
    logic             sign_ext;
    logic             big;
  } ld_ctx_t;

  // alignment test: address must be a multiple of the access size
  function automatic logic is_aligned(size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~off[0];
      SZ_WORD: return off == '0;
      default: return 1'b0;
    endcase
  endfunction

  // lanes covered by an access starting at lane 'off'
  function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return {{(LANES-1){1'b0}}, 1'b1} << off;
      SZ_HALF: return {{(LANES-2){1'b0}}, 2'b11} << off;
      SZ_WORD: return {LANES{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [15:0] swap16(logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  function automatic logic [DATA_W-1:0] swap_word(logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[i*BYTE_W +: BYTE_W] = d[(LANES-1-i)*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/mau_align_check.sv
module mau_align_check
  import mau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             store,
  input  size_e            size,
  input  logic [OFF_W-1:0] offset,
  output logic             misalign,
  output logic             wr_go,
  output logic             rd_go
);
  logic ok;

  always_comb begin
    ok       = is_aligned(size, offset);
    misalign = valid & ~ok;
    wr_go    = valid & ok & store;
    rd_go    = valid & ok & ~store;
  end

  assert_word_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_WORD && offset != '0) |-> misalign);

  assert_rsvd_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_RSVD) |-> (misalign && !wr_go && !rd_go));
endmodule

// File: rtl/mau_store_steer.sv
module mau_store_steer
  import mau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  size_e             size,
  input  logic [OFF_W-1:0]  offset,
  input  logic              big,
  input  logic [DATA_W-1:0] operand,
  output logic [LANES-1:0]  wen,
  output logic [DATA_W-1:0] wdata
);
  logic [15:0] half_img;

  always_comb begin
    half_img = big ? swap16(operand[15:0]) : operand[15:0];
    case (size)
      SZ_BYTE: wdata = {LANES{operand[BYTE_W-1:0]}};
      SZ_HALF: wdata = {(LANES/2){half_img}};
      default: wdata = big ? swap_word(operand) : operand;
    endcase
    wen = wr_go ? lane_mask(size, offset) : '0;
  end

  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && size == SZ_BYTE) |-> $countones(wen) == 1);

  assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && size == SZ_HALF) |-> $countones(wen) == 2);
endmodule

// File: rtl/mau_load_extract.sv
module mau_load_extract
  import mau_pkg::*;
(
  input  ld_ctx_t           ctx,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] shifted;
  logic [BYTE_W-1:0] b;
  logic [15:0]       h;

  always_comb begin
    shifted = rdata >> {ctx.offset, 3'b000};
    b       = shifted[BYTE_W-1:0];
    h       = ctx.big ? swap16(shifted[15:0]) : shifted[15:0];
    case (ctx.size)
      SZ_BYTE: value = {{(DATA_W-BYTE_W){ctx.sign_ext & b[BYTE_W-1]}}, b};
      SZ_HALF: value = {{(DATA_W-16){ctx.sign_ext & h[15]}}, h};
      default: value = ctx.big ? swap_word(rdata) : rdata;
    endcase
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              big_endian,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_wen,
  output logic [31:0]       mem_wdata,
  output logic              mem_ren,
  input  logic [31:0]       mem_rdata,
  output logic              misalign,
  output logic              load_valid,
  output logic [31:0]       load_data
);
  size_e            sz;
  logic [OFF_W-1:0] off;
  logic             wr_go;
  logic             rd_go;
  ld_ctx_t          ctx_q;

  assign sz       = size_e'(req_size);
  assign off      = req_addr[OFF_W-1:0];
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_ren  = rd_go;

  mau_align_check u_align (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .store(req_store),
    .size(sz), .offset(off), .misalign(misalign), .wr_go(wr_go), .rd_go(rd_go)
  );

  mau_store_steer u_steer (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .size(sz), .offset(off),
    .big(big_endian), .operand(req_wdata), .wen(mem_wen), .wdata(mem_wdata)
  );

  // load context held for the cycle in which memory returns data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      ctx_q      <= '{size: SZ_WORD, offset: '0, sign_ext: 1'b0, big: 1'b0};
    end else begin
      load_valid <= rd_go;
      if (rd_go) ctx_q <= '{size: sz, offset: off, sign_ext: req_signed, big: big_endian};
    end
  end

  mau_load_extract u_extract (
    .ctx(ctx_q), .rdata(mem_rdata), .value(load_data)
  );

  assert_misalign_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_wen == 4'b0000 && !mem_ren));

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ren |=> load_valid);

  assert_no_stray_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(mem_ren));

  assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'd2 && !misalign) |-> mem_wen == 4'b1111);
endmodule

// File: tb/tb_mem_access_unit.sv
module tb_mem_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
  logic [3:0]  mem_wen;
  logic        mem_ren, misalign, load_valid;

  int checks = 0;
  int errors = 0;

  logic [7:0] bmem    [64];  // lane-written memory behind the DUT
  logic [7:0] ref_mem [64];  // semantic reference memory

  always #5 clk = ~clk;

  mem_access_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .big_endian(big_endian), .mem_addr(mem_addr),
    .mem_wen(mem_wen), .mem_wdata(mem_wdata), .mem_ren(mem_ren),
    .mem_rdata(mem_rdata), .misalign(misalign), .load_valid(load_valid),
    .load_data(load_data)
  );

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (mem_wen[i]) bmem[mem_addr[5:0] + i] <= mem_wdata[8*i +: 8];
    end
    mem_rdata <= {bmem[mem_addr[5:0]+3], bmem[mem_addr[5:0]+2],
                  bmem[mem_addr[5:0]+1], bmem[mem_addr[5:0]]};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit aligned_ref(int addr, int sz);
    if (sz == 3) return 0;
    return (addr % (1 << sz)) == 0;
  endfunction

  task automatic do_store(input int addr, input int sz, input logic [31:0] val, input bit big);
    int n;
    bit al;
    logic [3:0] exp_wen;
    n = 1 << sz;
    al = aligned_ref(addr, sz);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = sz[1:0]; req_addr = addr;
    req_wdata = val; big_endian = big; req_signed = 0;
    #1;
    exp_wen = '0;
    if (al) for (int k = 0; k < n; k++) exp_wen[(addr % 4) + k] = 1'b1;
    chk(misalign == !al, "R3 misalign flag", {31'd0, misalign}, {31'd0, !al});
    chk(mem_wen == exp_wen, "R4 write enables", {28'd0, mem_wen}, {28'd0, exp_wen});
    chk(mem_addr == (addr & ~3), "R1 word address", mem_addr, addr & ~3);
    if (al && sz == 0)
      chk(mem_wdata == {4{val[7:0]}}, "R8 byte replication", mem_wdata, {4{val[7:0]}});
    if (al) begin
      for (int k = 0; k < n; k++)
        ref_mem[addr + k] = big ? val[8*(n-1-k) +: 8] : val[8*k +: 8];
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_load(input int addr, input int sz, input bit sgn, input bit big,
                         input bit disturb, input string req);
    int n;
    bit al;
    logic [31:0] v;
    n = 1 << sz;
    al = aligned_ref(addr, sz);
    v = '0;
    if (al) begin
      for (int k = 0; k < n; k++)
        v[8*k +: 8] = big ? ref_mem[addr + n - 1 - k] : ref_mem[addr + k];
      if (sgn && sz == 0 && v[7])  v = v - 32'd256;
      if (sgn && sz == 1 && v[15]) v = v - 32'd65536;
    end
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = sz[1:0]; req_addr = addr;
    req_signed = sgn; big_endian = big;
    #1;
    chk(mem_ren == al, "R9 read strobe", {31'd0, mem_ren}, {31'd0, al});
    chk(misalign == !al, "R3 misalign on load", {31'd0, misalign}, {31'd0, !al});
    @(negedge clk);
    req_valid = 0;
    if (disturb) begin  // R11: new mode and fields in result cycle
      big_endian = ~big; req_signed = ~sgn; req_size = 2'd2; req_addr = 32'h3;
    end
    #1;
    chk(load_valid == al, "R9 load_valid", {31'd0, load_valid}, {31'd0, al});
    if (al) chk(load_data == v, req, load_data, v);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    chk(load_valid == 0, "R12 reset load_valid", {31'd0, load_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(load_valid == 0 && mem_wen == 0, "R12 idle after reset", {28'd0, mem_wen}, 32'd0);

    // little-endian word round trip, then byte view (R6, R5)
    do_store(8, 2, 32'h11223344, 0);
    do_load(8, 2, 0, 0, 0, "R6 word little");
    do_load(8, 0, 0, 0, 0, "R6 lowest byte is LSB");
    do_load(11, 0, 0, 0, 0, "R5 lane 3 byte");
    // big-endian word, read as bytes and halves (R7)
    do_store(16, 2, 32'hA1B2C3D4, 1);
    do_load(16, 0, 0, 1, 0, "R7 lowest byte is MSB");
    do_load(16, 2, 0, 1, 0, "R7 word big");
    do_load(16, 2, 0, 0, 0, "R6 big data read little");
    do_load(18, 1, 0, 1, 0, "R7 half big");
    // halfwords both orders (R8, R10)
    do_store(22, 1, 32'h0000F00D, 0);
    do_load(22, 1, 1, 0, 0, "R10 half signed little");
    do_load(22, 1, 0, 0, 0, "R10 half unsigned little");
    do_store(24, 1, 32'h00008181, 1);
    do_load(24, 1, 1, 1, 0, "R8 half big signed");
    // bytes with sign (R10, R8)
    do_store(29, 0, 32'h000000F3, 1);
    do_load(29, 0, 1, 1, 0, "R10 byte signed");
    do_load(29, 0, 0, 0, 0, "R10 byte unsigned");
    do_store(30, 0, 32'h0000007E, 0);
    do_load(30, 0, 1, 0, 0, "R10 positive byte signed");
    // misaligned stores leave memory untouched (R3, R2)
    do_store(33, 2, 32'hDEADBEEF, 0);
    do_store(35, 1, 32'h0000CAFE, 1);
    do_store(36, 3, 32'h12345678, 0);
    do_load(32, 2, 0, 0, 0, "R3 memory untouched by misaligned stores");
    do_load(36, 2, 0, 1, 0, "R2 reserved size wrote nothing");
    // misaligned loads give no result (R2, R9)
    do_load(41, 1, 0, 0, 0, "R2 half odd");
    do_load(42, 2, 0, 0, 0, "R2 word offset 2");
    // context captured at request time (R11)
    do_store(44, 2, 32'h80C0E0F0, 1);
    do_load(44, 2, 0, 1, 1, "R11 word order held");
    do_load(46, 1, 1, 0, 1, "R11 half sign held");
    do_load(47, 0, 1, 1, 1, "R11 byte held");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule